// File: doc/BRIEF.md
# Batcher Odd-Even Merge Sorter

This block sorts a vector of `N` unsigned elements at once and presents them in ascending order. The network is built by recursion over `N`: each half of the input is sorted by a sorter of half the size, and an odd-even merger of full size combines the two sorted halves. The merger itself recurses. It merges the even-indexed and the odd-indexed subsequences separately, then applies one final layer of compare-exchange cells to neighbouring positions. Both recursions end at a single two-input compare-exchange cell. No comparator list is written by hand.

The element width `W` is a parameter, and `W = 1` is a legal configuration. A one-bit instance can therefore be swept over every 0/1 pattern, and a lone merger can be driven with every pair of sorted halves. `PIPE` chooses between a purely combinational network and one register after every comparator layer. A valid flag travels beside the data with the same delay. `N` must be a power of two of at least 2, and any other value stops elaboration with an error. Element `i` occupies bits `[i*W +: W]` of a data bus. Element 0 is the lowest index and, after sorting, holds the smallest value.

The merger is named `sort_merge`. Its submerger ordering follows the recursion above, and its final layer pairs positions (1,2), (3,4) … (N-3,N-2).

Top module: `batcher_sorter`

## Requirements
- R1: Whenever `out_valid` is high, the output elements are non-decreasing from index 0 to index N-1, with element `i` at bits `[i*W +: W]`.
- R2: The output holds exactly the multiset of the input vector it came from. Duplicated values keep their multiplicity.
- R3: Every compare-exchange cell drives the smaller of its two inputs onto its lower-index output and the larger onto its higher-index output. Equal inputs leave both outputs equal to that value.
- R4: With `PIPE = 1`, the sorted form of a vector sampled on a clock edge, together with its valid flag, appears exactly L = log2(N)·(log2(N)+1)/2 edges later. A new vector is accepted on every cycle.
- R5: With `PIPE = 0`, the output is the sorted input in the same cycle, and `out_valid` equals `in_valid`.
- R6: A vector sampled while `in_valid` is low still passes through the network in sorted form, but `out_valid` stays low in the cycle in which it emerges.
- R7: The merger `sort_merge` of size N sorts its input whenever elements 0..N/2-1 and N/2..N-1 are each non-decreasing. With registers enabled it has a latency of log2(N) edges.
- R8: With `W = 1`, any 0/1 input produces an output of all zeros at the low indices followed by all ones, with the count of ones preserved.
- R9: While `rst_n` is low, `out_valid` is low and every pipeline register is cleared, so `out_data` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a vector to be sorted |
| in_data | input | N*W | Unsorted elements, element i at bits [i*W +: W] |
| out_valid | output | 1 | Marks `out_data` as the result of a valid input |
| out_data | output | N*W | Sorted elements, smallest at index 0 |

## Verification
The merger's ordering check relies on an input promise: each half of every vector reaching a merger is already in order. Inside the sorter this holds because every merger is fed by half sorters. When a merger is driven on its own, the stimulus builds every vector from two sorted halves, and the merger input starts at all zeros. The cell-level checks assume that inputs are known from the first edge after reset, so every bench input is set to zero at time zero. The full sorter accepts any data and any valid pattern. Its streamed vectors therefore mix distinct values, duplicates and idle cycles freely.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

    // ceiling log2 for positive sizes
    function automatic int lg2(input int n);
        int r;
        r = 0;
        while ((1 << r) < n) r++;
        return r;
    endfunction

    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    // comparator layers in a merger of size n
    function automatic int merge_layers(input int n);
        return lg2(n);
    endfunction

    // comparator layers in a full sorter of size n
    function automatic int sort_layers(input int n);
        return (lg2(n) * (lg2(n) + 1)) / 2;
    endfunction

endpackage

// File: rtl/sort_dly.sv
module sort_dly #(
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (PIPE) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            logic unused_ctl;
            assign unused_ctl = clk ^ rst_n;
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/sort_cx.sv
module sort_cx #(
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);

    logic         swap;
    logic [W-1:0] lo_c;
    logic [W-1:0] hi_c;

    always_comb begin
        swap = (a > b);
        lo_c = swap ? b : a;
        hi_c = swap ? a : b;
    end

    generate
        if (PIPE) begin : g_reg
            logic live;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lo   <= '0;
                    hi   <= '0;
                    live <= 1'b0;
                end else begin
                    lo   <= lo_c;
                    hi   <= hi_c;
                    live <= 1'b1;
                end
            end

            // R2: a registered cell neither loses nor invents value
            p_cx_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
                live |-> ({1'b0, lo} + {1'b0, hi}) == $past({1'b0, a} + {1'b0, b}));
        end else begin : g_wire
            assign lo = lo_c;
            assign hi = hi_c;
        end
    endgenerate

    // R3: lower output never exceeds the upper one
    p_cx_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo <= hi);

endmodule

// File: rtl/sort_merge.sv
module sort_merge #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);

    localparam int H = N / 2;

    generate
        if (N == 2) begin : g_leaf
            sort_cx #(.W(W), .PIPE(PIPE)) u_cx (
                .clk  (clk),
                .rst_n(rst_n),
                .a    (din[0 +: W]),
                .b    (din[W +: W]),
                .lo   (dout[0 +: W]),
                .hi   (dout[W +: W])
            );
        end else begin : g_rec
            logic [H*W-1:0] ev_in;
            logic [H*W-1:0] od_in;
            logic [H*W-1:0] ev_out;
            logic [H*W-1:0] od_out;
            logic [N*W-1:0] mix;

            for (genvar i = 0; i < H; i++) begin : g_split
                assign ev_in[i*W +: W]       = din[(2*i)*W +: W];
                assign od_in[i*W +: W]       = din[(2*i+1)*W +: W];
                assign mix[(2*i)*W +: W]     = ev_out[i*W +: W];
                assign mix[(2*i+1)*W +: W]   = od_out[i*W +: W];
            end

            sort_merge #(.N(H), .W(W), .PIPE(PIPE)) u_even (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (ev_in),
                .dout (ev_out)
            );

            sort_merge #(.N(H), .W(W), .PIPE(PIPE)) u_odd (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (od_in),
                .dout (od_out)
            );

            // end positions are already final; they only keep step
            sort_dly #(.W(W), .PIPE(PIPE)) u_first (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (mix[0 +: W]),
                .q    (dout[0 +: W])
            );

            sort_dly #(.W(W), .PIPE(PIPE)) u_last (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (mix[(N-1)*W +: W]),
                .q    (dout[(N-1)*W +: W])
            );

            // closing layer on neighbours (2k-1, 2k)
            for (genvar k = 1; k < H; k++) begin : g_fix
                sort_cx #(.W(W), .PIPE(PIPE)) u_cx (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .a    (mix[(2*k-1)*W +: W]),
                    .b    (mix[(2*k)*W +: W]),
                    .lo   (dout[(2*k-1)*W +: W]),
                    .hi   (dout[(2*k)*W +: W])
                );
            end
        end
    endgenerate

    logic ord_ok;
    always_comb begin
        ord_ok = 1'b1;
        for (int i = 0; i < N - 1; i++) begin
            if (dout[i*W +: W] > dout[(i+1)*W +: W]) ord_ok = 1'b0;
        end
    end

    // R7: with sorted halves on the input, the merged output is ordered
    p_mrg_sorted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ord_ok);

endmodule

// File: rtl/sort_net.sv
module sort_net #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N*W-1:0] din,
    output logic [N*W-1:0] dout
);

    localparam int H = N / 2;

    generate
        if (N == 2) begin : g_leaf
            sort_cx #(.W(W), .PIPE(PIPE)) u_cx (
                .clk  (clk),
                .rst_n(rst_n),
                .a    (din[0 +: W]),
                .b    (din[W +: W]),
                .lo   (dout[0 +: W]),
                .hi   (dout[W +: W])
            );
        end else begin : g_rec
            logic [N*W-1:0] halves;

            sort_net #(.N(H), .W(W), .PIPE(PIPE)) u_low (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (din[0 +: H*W]),
                .dout (halves[0 +: H*W])
            );

            sort_net #(.N(H), .W(W), .PIPE(PIPE)) u_high (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (din[H*W +: H*W]),
                .dout (halves[H*W +: H*W])
            );

            sort_merge #(.N(N), .W(W), .PIPE(PIPE)) u_merge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (halves),
                .dout (dout)
            );
        end
    endgenerate

endmodule

// File: rtl/batcher_sorter.sv
module batcher_sorter #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N*W-1:0] out_data
);

    import sorter_pkg::*;

    localparam int LAT = PIPE ? sort_layers(N) : 0;

    generate
        if (!is_pow2(N)) begin : g_bad_size
            $error("batcher_sorter: N must be a power of two, at least 2");
        end
    endgenerate

    sort_net #(.N(N), .W(W), .PIPE(PIPE)) u_net (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (in_data),
        .dout (out_data)
    );

    generate
        if (LAT > 0) begin : g_vpipe
            logic [LAT-1:0] vsh;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vsh <= '0;
                end else begin
                    vsh[0] <= in_valid;
                    for (int i = 1; i < LAT; i++) vsh[i] <= vsh[i-1];
                end
            end

            assign out_valid = vsh[LAT-1];
        end else begin : g_vwire
            assign out_valid = in_valid;
        end
    endgenerate

    logic ord_ok;
    always_comb begin
        ord_ok = 1'b1;
        for (int i = 0; i < N - 1; i++) begin
            if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) ord_ok = 1'b0;
        end
    end

    // R1: every valid result is ordered
    p_out_sorted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ord_ok);

endmodule

// File: tb/tb_batcher_sorter.sv
module tb_batcher_sorter;

    localparam int TN  = 8;
    localparam int TW  = 4;
    localparam int LAT = 6;     // log2(8)*(log2(8)+1)/2
    localparam int MLAT = 3;    // log2(8)
    localparam int M   = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;      // 50 MHz

    logic             in_valid = 1'b0;
    logic [TN*TW-1:0] in_data  = '0;
    logic             out_valid;
    logic [TN*TW-1:0] out_data;

    logic             b_vld = 1'b0;
    logic [TN-1:0]    b_in  = '0;
    logic             b_ovld;
    logic [TN-1:0]    b_out;

    logic [TN-1:0]    m_in  = '0;
    logic [TN-1:0]    m_out;

    batcher_sorter #(.N(TN), .W(TW), .PIPE(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    batcher_sorter #(.N(TN), .W(1), .PIPE(1'b0)) u_bit (
        .clk(clk), .rst_n(rst_n), .in_valid(b_vld), .in_data(b_in),
        .out_valid(b_ovld), .out_data(b_out)
    );

    sort_merge #(.N(TN), .W(1), .PIPE(1'b1)) u_mrg (
        .clk(clk), .rst_n(rst_n), .din(m_in), .dout(m_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [TN*TW-1:0] ref_sort(input logic [TN*TW-1:0] v);
        logic [TW-1:0] e [TN];
        logic [TW-1:0] t;
        logic [TN*TW-1:0] r;
        for (int i = 0; i < TN; i++) e[i] = v[i*TW +: TW];
        for (int i = 0; i < TN; i++)
            for (int j = 0; j < TN - 1 - i; j++)
                if (e[j] > e[j+1]) begin
                    t = e[j]; e[j] = e[j+1]; e[j+1] = t;
                end
        for (int i = 0; i < TN; i++) r[i*TW +: TW] = e[i];
        return r;
    endfunction

    function automatic logic [TN-1:0] ones_top(input int cnt);
        logic [TN-1:0] r;
        r = '0;
        for (int i = 0; i < cnt; i++) r[TN-1-i] = 1'b1;
        return r;
    endfunction

    function automatic logic [TN/2-1:0] half_ones(input int cnt);
        logic [TN/2-1:0] r;
        r = '0;
        for (int i = 0; i < cnt; i++) r[TN/2-1-i] = 1'b1;
        return r;
    endfunction

    logic [TN*TW-1:0] vec [M];
    logic             vv  [M];

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] s;
        s = 32'h1234_5678;

        // stimulus tables
        for (int k = 0; k < M; k++) begin
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            vec[k] = s;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            vv[k] = (k < 12) ? 1'b1 : s[3];
        end
        vec[0] = 32'h7777_7777;     // all equal
        vec[1] = 32'h7654_3210;     // already ascending
        vec[2] = 32'h0123_4567;     // descending
        vec[3] = 32'hFFFF_FFFF;
        vec[4] = 32'h0000_0000;
        vec[5] = 32'hF0F0_F0F0;     // 0-1 style, wide encoding
        vec[6] = 32'h3311_3311;     // duplicates
        vv[14] = 1'b0;              // guaranteed idle slot

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R9 out_data in reset", {32'd0, out_data}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 out_valid after release", {63'd0, out_valid}, 64'd0);
        check("R9 out_data after release", {32'd0, out_data}, 64'd0);

        // R1 R2 R3 R4 R6: streamed vectors, one per cycle
        for (int c = 0; c < M + LAT; c++) begin
            if (c > 0) @(negedge clk);
            if (c >= LAT) begin
                check("R4 R6 out_valid timing", {63'd0, out_valid}, {63'd0, vv[c-LAT]});
                check("R1 R2 R3 sorted data", {32'd0, out_data}, {32'd0, ref_sort(vec[c-LAT])});
            end else begin
                check("R4 out_valid before first result", {63'd0, out_valid}, 64'd0);
            end
            if (c < M) begin
                in_valid = vv[c];
                in_data  = vec[c];
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
        end

        // R8 R5: every 0/1 pattern on the one-bit, combinational instance
        for (int p = 0; p < (1 << TN); p++) begin
            @(negedge clk);
            b_in  = p[TN-1:0];
            b_vld = p[0];
            #2;
            check("R8 zeros then ones", {56'd0, b_out}, {56'd0, ones_top($countones(p[TN-1:0]))});
            check("R5 valid follows input", {63'd0, b_ovld}, {63'd0, p[0]});
        end

        // R7: merger alone, every pair of sorted 0/1 halves
        for (int a = 0; a <= TN/2; a++) begin
            for (int b = 0; b <= TN/2; b++) begin
                @(negedge clk);
                m_in = {half_ones(b), half_ones(a)};
                repeat (MLAT) @(negedge clk);
                check("R7 merged halves", {56'd0, m_out}, {56'd0, ones_top(a + b)});
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule